// File: doc/BRIEF.md
# Vector Byte-Align and Lane Permutation Unit

This block rearranges the lanes of two 64-bit source vectors, `vecS` and `vecT`, into one 64-bit result. The selected operation is worked out combinationally and captured in an output register. It is meant to sit beside a media datapath. There it produces realigned byte streams for unaligned loads and packed or widened lane layouts for later arithmetic. It does no arithmetic itself.

Lane numbering: byte lane i is bits [8i+7:8i] and halfword lane i is bits [16i+15:16i], with lane 0 at the least significant end. The operation is picked by a 4-bit `mode`. Pack and interleave work on bytes or halfwords, chosen by `halfFmt`. Unpack always turns bytes into halfwords. The butterfly and replicate patterns always work on halfwords. Alignment builds a 128-bit value with `vecS` in the upper half and `vecT` in the lower half, then takes a 64-bit window at a byte offset of 0 to 7. The position of that window depends on `bigEndian`.

Top module: `vperm_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `modeErr` and `outVec` are 0.
- R2: A request with `inValid` high at a clock edge shows its result on `outVec`/`modeErr`, with `outValid` high, after that edge. When `inValid` is low, `outValid` drops to 0 after the edge and `outVec` keeps its previous value.
- R3: Mode 0 with `bigEndian`=1 and offset s gives bits [127-8s : 64-8s] of {vecS,vecT}. An offset of 0 therefore gives `vecS`.
- R4: Mode 0 with `bigEndian`=0 and offset s gives bits [63+8s : 8s] of {vecS,vecT}. An offset of 0 therefore gives `vecT`.
- R5: The offset is `immOffset` when `useRegOffset`=0. It is bits [2:0] of `regOffset` when `useRegOffset`=1. The upper bits of `regOffset` have no effect.
- R6: `bigEndian` has no effect on any mode other than 0.
- R7: Modes 1 (even) and 2 (odd), with N lanes: result lane i = vecT lane 2i (or 2i+1), and result lane N/2+i = vecS lane 2i (or 2i+1), for i < N/2. The lanes are bytes when `halfFmt`=0 and halfwords when `halfFmt`=1.
- R8: Modes 3 (low) and 4 (high), with N lanes: result lane 2i = vecT lane i+b, and result lane 2i+1 = vecS lane i+b, for i < N/2. Here b is 0 for low and N/2 for high. The lanes are bytes or halfwords as in R7.
- R9: Modes 5 and 6 zero-extend vecS byte lanes 0..3 (mode 5) or 4..7 (mode 6) into halfword lanes 0..3. Modes 7 and 8 sign-extend the same lower and upper byte sets.
- R10: Modes 9 to 12 give halfword lanes 0..3 as follows. Mode 9: T1,S0,T3,S2. Mode 10: T3,S2,T1,S0. Mode 11: T2,T3,S2,S3. Mode 12: T0,T1,S0,S1.
- R11: Modes 13 to 15 give `outVec`=0 with `modeErr`=1. Every other mode gives `modeErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| mode | input | 4 | Operation code (see requirements) |
| halfFmt | input | 1 | Lane width for pack and interleave: 0 byte, 1 halfword |
| bigEndian | input | 1 | Alignment window direction |
| useRegOffset | input | 1 | Take the offset from regOffset instead of immOffset |
| immOffset | input | 3 | Immediate byte offset |
| regOffset | input | 64 | Register value; only bits [2:0] are used |
| vecS | input | 64 | Source vector S |
| vecT | input | 64 | Source vector T |
| outValid | output | 1 | Result valid |
| outVec | output | 64 | Registered result |
| modeErr | output | 1 | Unused mode code was requested |

## Verification
The bench aims at offsets 0 and 7 in both endian modes. A window placed one byte wrong, or endian modes swapped, would return the wrong source at offset 0 or lose a byte at offset 7. It sets register offsets with the upper bits all ones, to catch a decoder that reads too many bits. It checks signed unpack with bytes whose top bit is set, to catch extension of the wrong polarity. It compares the pack, interleave and fixed halfword patterns lane by lane on sources where every byte is distinct, so a lane swap or a wrong half shows up at once. Last, it feeds the three unused codes, checks that the output holds while idle, and toggles the endian input on non-align modes.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [3:0] {
    OP_ALIGN     = 4'd0,
    OP_PACK_EVEN = 4'd1,
    OP_PACK_ODD  = 4'd2,
    OP_MIX_LO    = 4'd3,
    OP_MIX_HI    = 4'd4,
    OP_UNPK_ULO  = 4'd5,
    OP_UNPK_UHI  = 4'd6,
    OP_UNPK_SLO  = 4'd7,
    OP_UNPK_SHI  = 4'd8,
    OP_BFLY_A    = 4'd9,
    OP_BFLY_B    = 4'd10,
    OP_REP_A     = 4'd11,
    OP_REP_B     = 4'd12
  } permOp_e;

  typedef enum logic [2:0] {
    GRP_NONE   = 3'd0,
    GRP_ALIGN  = 3'd1,
    GRP_PACK   = 3'd2,
    GRP_MIX    = 3'd3,
    GRP_UNPACK = 3'd4,
    GRP_FIXED  = 3'd5
  } permGrp_e;

  // Strobes from control to datapath and output stage
  typedef struct packed {
    permGrp_e   group;
    logic       oddLanes;
    logic       upperHalf;
    logic       halfFmt;
    logic       signExt;
    logic [1:0] fixedSel;
    logic       bigEndian;
    logic       badMode;
    logic       load;
  } permCtrl_t;

endpackage

// File: rtl/perm_ctrl.sv
module perm_ctrl
  import perm_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int OFS_W = 3
) (
  input  logic             inValid,
  input  logic [3:0]       mode,
  input  logic             halfFmt,
  input  logic             bigEndian,
  input  logic             useRegOffset,
  input  logic [OFS_W-1:0] immOffset,
  input  logic [REG_W-1:0] regOffset,
  output permCtrl_t        ctrl,
  output logic [OFS_W-1:0] offset
);

  // Only the low bits of the register value form the offset
  logic unusedRegBits;
  assign unusedRegBits = ^regOffset[REG_W-1:OFS_W];

  assign offset = useRegOffset ? regOffset[OFS_W-1:0] : immOffset;

  always_comb begin
    ctrl           = '0;
    ctrl.group     = GRP_NONE;
    ctrl.halfFmt   = halfFmt;
    ctrl.bigEndian = bigEndian;
    ctrl.load      = inValid;
    unique case (mode)
      OP_ALIGN:     ctrl.group = GRP_ALIGN;
      OP_PACK_EVEN: ctrl.group = GRP_PACK;
      OP_PACK_ODD: begin
        ctrl.group    = GRP_PACK;
        ctrl.oddLanes = 1'b1;
      end
      OP_MIX_LO:    ctrl.group = GRP_MIX;
      OP_MIX_HI: begin
        ctrl.group     = GRP_MIX;
        ctrl.upperHalf = 1'b1;
      end
      OP_UNPK_ULO:  ctrl.group = GRP_UNPACK;
      OP_UNPK_UHI: begin
        ctrl.group     = GRP_UNPACK;
        ctrl.upperHalf = 1'b1;
      end
      OP_UNPK_SLO: begin
        ctrl.group   = GRP_UNPACK;
        ctrl.signExt = 1'b1;
      end
      OP_UNPK_SHI: begin
        ctrl.group     = GRP_UNPACK;
        ctrl.signExt   = 1'b1;
        ctrl.upperHalf = 1'b1;
      end
      OP_BFLY_A: begin
        ctrl.group    = GRP_FIXED;
        ctrl.fixedSel = 2'd0;
      end
      OP_BFLY_B: begin
        ctrl.group    = GRP_FIXED;
        ctrl.fixedSel = 2'd1;
      end
      OP_REP_A: begin
        ctrl.group    = GRP_FIXED;
        ctrl.fixedSel = 2'd2;
      end
      OP_REP_B: begin
        ctrl.group    = GRP_FIXED;
        ctrl.fixedSel = 2'd3;
      end
      default: ctrl.badMode = 1'b1;
    endcase
  end

endmodule

// File: rtl/perm_datapath.sv
module perm_datapath
  import perm_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int OFS_W = 3
) (
  input  permCtrl_t        ctrl,
  input  logic [OFS_W-1:0] offset,
  input  logic [VEC_W-1:0] vecS,
  input  logic [VEC_W-1:0] vecT,
  output logic [VEC_W-1:0] result
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int NB     = VEC_W / BYTE_W;
  localparam int NH     = VEC_W / HALF_W;
  localparam int NGRP   = NH / 4;
  localparam int IDX_W  = $clog2(2 * VEC_W);

  logic unusedCtrlBits;
  assign unusedCtrlBits = ctrl.load ^ ctrl.badMode;

  // ---------------- alignment window ----------------
  logic [2*VEC_W-1:0] joined;
  logic [IDX_W-1:0]   winLow;
  logic [VEC_W-1:0]   alignRes;

  assign joined = {vecS, vecT};

  always_comb begin
    if (ctrl.bigEndian)
      winLow = IDX_W'(VEC_W - BYTE_W * int'(offset));
    else
      winLow = IDX_W'(BYTE_W * int'(offset));
    alignRes = joined[winLow +: VEC_W];
  end

  // ---------------- pack even / odd ----------------
  logic [VEC_W-1:0] packB, packH;
  always_comb begin
    packB = '0;
    packH = '0;
    for (int i = 0; i < NB / 2; i++) begin
      packB[BYTE_W*i +: BYTE_W] =
        vecT[BYTE_W*(2*i + int'(ctrl.oddLanes)) +: BYTE_W];
      packB[BYTE_W*(i + NB/2) +: BYTE_W] =
        vecS[BYTE_W*(2*i + int'(ctrl.oddLanes)) +: BYTE_W];
    end
    for (int i = 0; i < NH / 2; i++) begin
      packH[HALF_W*i +: HALF_W] =
        vecT[HALF_W*(2*i + int'(ctrl.oddLanes)) +: HALF_W];
      packH[HALF_W*(i + NH/2) +: HALF_W] =
        vecS[HALF_W*(2*i + int'(ctrl.oddLanes)) +: HALF_W];
    end
  end

  // ---------------- interleave low / high ----------------
  logic [VEC_W-1:0] mixB, mixH;
  always_comb begin
    mixB = '0;
    mixH = '0;
    for (int i = 0; i < NB / 2; i++) begin
      mixB[BYTE_W*(2*i) +: BYTE_W] =
        vecT[BYTE_W*(i + (ctrl.upperHalf ? NB/2 : 0)) +: BYTE_W];
      mixB[BYTE_W*(2*i+1) +: BYTE_W] =
        vecS[BYTE_W*(i + (ctrl.upperHalf ? NB/2 : 0)) +: BYTE_W];
    end
    for (int i = 0; i < NH / 2; i++) begin
      mixH[HALF_W*(2*i) +: HALF_W] =
        vecT[HALF_W*(i + (ctrl.upperHalf ? NH/2 : 0)) +: HALF_W];
      mixH[HALF_W*(2*i+1) +: HALF_W] =
        vecS[HALF_W*(i + (ctrl.upperHalf ? NH/2 : 0)) +: HALF_W];
    end
  end

  // ---------------- byte to halfword widening ----------------
  logic [VEC_W-1:0] unpackRes;
  generate
    for (genvar h = 0; h < NH; h++) begin : g_unpack
      logic [BYTE_W-1:0] srcByte;
      assign srcByte = ctrl.upperHalf ? vecS[BYTE_W*(h+NH) +: BYTE_W]
                                      : vecS[BYTE_W*h +: BYTE_W];
      assign unpackRes[HALF_W*h +: HALF_W] =
        {{BYTE_W{ctrl.signExt & srcByte[BYTE_W-1]}}, srcByte};
    end
  endgenerate

  // ---------------- fixed halfword patterns, per group of four ----------------
  logic [VEC_W-1:0] fixedRes;
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_fixed
      logic [HALF_W-1:0] t0, t1, t2, t3, s0, s1, s2, s3;
      assign t0 = vecT[HALF_W*(4*g+0) +: HALF_W];
      assign t1 = vecT[HALF_W*(4*g+1) +: HALF_W];
      assign t2 = vecT[HALF_W*(4*g+2) +: HALF_W];
      assign t3 = vecT[HALF_W*(4*g+3) +: HALF_W];
      assign s0 = vecS[HALF_W*(4*g+0) +: HALF_W];
      assign s1 = vecS[HALF_W*(4*g+1) +: HALF_W];
      assign s2 = vecS[HALF_W*(4*g+2) +: HALF_W];
      assign s3 = vecS[HALF_W*(4*g+3) +: HALF_W];
      always_comb begin
        unique case (ctrl.fixedSel)
          2'd0:    fixedRes[4*HALF_W*g +: 4*HALF_W] = {s2, t3, s0, t1};
          2'd1:    fixedRes[4*HALF_W*g +: 4*HALF_W] = {s0, t1, s2, t3};
          2'd2:    fixedRes[4*HALF_W*g +: 4*HALF_W] = {s3, s2, t3, t2};
          default: fixedRes[4*HALF_W*g +: 4*HALF_W] = {s1, s0, t1, t0};
        endcase
      end
    end
  endgenerate

  // ---------------- final select ----------------
  always_comb begin
    unique case (ctrl.group)
      GRP_ALIGN:  result = alignRes;
      GRP_PACK:   result = ctrl.halfFmt ? packH : packB;
      GRP_MIX:    result = ctrl.halfFmt ? mixH : mixB;
      GRP_UNPACK: result = unpackRes;
      GRP_FIXED:  result = fixedRes;
      default:    result = '0;
    endcase
  end

endmodule

// File: rtl/perm_outreg.sv
module perm_outreg
  import perm_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  permCtrl_t        ctrl,
  input  logic [VEC_W-1:0] result,
  output logic             outValid,
  output logic [VEC_W-1:0] outVec,
  output logic             modeErr
);

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^{ctrl.group, ctrl.oddLanes, ctrl.upperHalf,
                            ctrl.halfFmt, ctrl.signExt, ctrl.fixedSel,
                            ctrl.bigEndian};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outVec   <= '0;
      modeErr  <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outVec  <= result;
        modeErr <= ctrl.badMode;
      end
    end
  end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import perm_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int REG_W = 64,
  parameter int OFS_W = $clog2(VEC_W / 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       mode,
  input  logic             halfFmt,
  input  logic             bigEndian,
  input  logic             useRegOffset,
  input  logic [OFS_W-1:0] immOffset,
  input  logic [REG_W-1:0] regOffset,
  input  logic [VEC_W-1:0] vecS,
  input  logic [VEC_W-1:0] vecT,
  output logic             outValid,
  output logic [VEC_W-1:0] outVec,
  output logic             modeErr
);

  permCtrl_t        ctrl;
  logic [OFS_W-1:0] offset;
  logic [VEC_W-1:0] result;

  perm_ctrl #(.REG_W(REG_W), .OFS_W(OFS_W)) u_ctrl (
    .inValid(inValid), .mode(mode), .halfFmt(halfFmt),
    .bigEndian(bigEndian), .useRegOffset(useRegOffset),
    .immOffset(immOffset), .regOffset(regOffset),
    .ctrl(ctrl), .offset(offset)
  );

  perm_datapath #(.VEC_W(VEC_W), .OFS_W(OFS_W)) u_dp (
    .ctrl(ctrl), .offset(offset), .vecS(vecS), .vecT(vecT), .result(result)
  );

  perm_outreg #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .result(result),
    .outValid(outValid), .outVec(outVec), .modeErr(modeErr)
  );

endmodule

// File: rtl/perm_checker.sv
module perm_checker #(
  parameter int VEC_W = 64,
  parameter int OFS_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [3:0]       mode,
  input logic             bigEndian,
  input logic             useRegOffset,
  input logic [OFS_W-1:0] immOffset,
  input logic [VEC_W-1:0] vecS,
  input logic [VEC_W-1:0] vecT,
  input logic             outValid,
  input logic [VEC_W-1:0] outVec,
  input logic             modeErr
);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outVec)));

  assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode > 4'd12) |=> (modeErr && outVec == '0));

  assert_good_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode <= 4'd12) |=> !modeErr);

  assert_align_be_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 4'd0 && bigEndian && !useRegOffset && immOffset == '0)
      |=> outVec == $past(vecS));

  assert_align_le_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 4'd0 && !bigEndian && !useRegOffset && immOffset == '0)
      |=> outVec == $past(vecT));

endmodule

bind vperm_unit perm_checker #(.VEC_W(VEC_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
  .bigEndian(bigEndian), .useRegOffset(useRegOffset), .immOffset(immOffset),
  .vecS(vecS), .vecT(vecT), .outValid(outValid), .outVec(outVec),
  .modeErr(modeErr)
);

// File: tb/sim_vperm_unit.sv
module sim_vperm_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SA = 64'h8877665544332211;
  localparam logic [63:0] TB = 64'hF7E6D5C4B3A29180;
  localparam logic [63:0] HIGHJUNK = 64'hFFFF_FFFF_FFFF_FFF8;

  typedef struct packed {
    logic [3:0]  m;
    logic        hf;
    logic        be;
    logic        ur;
    logic [2:0]  imm;
    logic [63:0] rg;
    logic [63:0] vs;
    logic [63:0] vt;
  } stim_t;

  localparam int NV = 29;
  localparam stim_t TBL [NV] = '{
    '{4'd0, 1'b0, 1'b1, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd0, 1'b0, 1'b1, 1'b0, 3'd3, 64'd0, SA, TB},
    '{4'd0, 1'b0, 1'b1, 1'b0, 3'd7, 64'd0, SA, TB},
    '{4'd0, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd0, 1'b0, 1'b0, 1'b0, 3'd5, 64'd0, SA, TB},
    '{4'd0, 1'b0, 1'b0, 1'b0, 3'd7, 64'd0, SA, TB},
    '{4'd0, 1'b0, 1'b1, 1'b1, 3'd0, HIGHJUNK | 64'd2, SA, TB},
    '{4'd0, 1'b0, 1'b0, 1'b1, 3'd6, 64'h8000_0000_0000_0001, SA, TB},
    '{4'd1, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd2, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd1, 1'b1, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd2, 1'b1, 1'b1, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd3, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd4, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd3, 1'b1, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd4, 1'b1, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd5, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, TB, SA},
    '{4'd6, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, TB, SA},
    '{4'd7, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, TB, SA},
    '{4'd8, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, TB, SA},
    '{4'd9, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd9, 1'b0, 1'b1, 1'b0, 3'd4, 64'd0, SA, TB},
    '{4'd10, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd11, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd12, 1'b0, 1'b1, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd13, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd14, 1'b1, 1'b1, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd15, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB},
    '{4'd7, 1'b0, 1'b1, 1'b0, 3'd0, 64'd0, 64'h00FF_7F80_0102_FE81, SA}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  mode = '0;
  logic        halfFmt = 1'b0;
  logic        bigEndian = 1'b0;
  logic        useRegOffset = 1'b0;
  logic [2:0]  immOffset = '0;
  logic [63:0] regOffset = '0;
  logic [63:0] vecS = '0;
  logic [63:0] vecT = '0;
  logic        outValid;
  logic [63:0] outVec;
  logic        modeErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vperm_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .halfFmt(halfFmt), .bigEndian(bigEndian), .useRegOffset(useRegOffset),
    .immOffset(immOffset), .regOffset(regOffset), .vecS(vecS), .vecT(vecT),
    .outValid(outValid), .outVec(outVec), .modeErr(modeErr)
  );

  function automatic logic [15:0] lane(input logic [63:0] v, input int w, input int i);
    return 16'((v >> (w * i)) & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic logic [63:0] put(input logic [63:0] v, input int w,
                                      input int i, input logic [15:0] x);
    logic [63:0] m;
    m = ((64'd1 << w) - 64'd1) << (w * i);
    return (v & ~m) | ((64'(x) << (w * i)) & m);
  endfunction

  // Reference model written from the requirement text; bit 64 is the error flag
  function automatic logic [64:0] refModel(input stim_t s);
    logic [63:0] r;
    logic [7:0]  jb [16];
    int ofs, w, n, pick;
    logic [7:0]  b;
    r = '0;
    ofs = s.ur ? int'(s.rg[2:0]) : int'(s.imm);
    w = s.hf ? 16 : 8;
    n = 64 / w;
    for (int k = 0; k < 8; k++) begin
      jb[k]     = s.vt[8*k +: 8];
      jb[k + 8] = s.vs[8*k +: 8];
    end
    case (s.m)
      4'd0:
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = s.be ? jb[8 - ofs + k] : jb[ofs + k];
      4'd1, 4'd2:
        for (int i = 0; i < n / 2; i++) begin
          pick = 2 * i + ((s.m == 4'd2) ? 1 : 0);
          r = put(r, w, i, lane(s.vt, w, pick));
          r = put(r, w, n / 2 + i, lane(s.vs, w, pick));
        end
      4'd3, 4'd4:
        for (int i = 0; i < n / 2; i++) begin
          pick = i + ((s.m == 4'd4) ? n / 2 : 0);
          r = put(r, w, 2 * i, lane(s.vt, w, pick));
          r = put(r, w, 2 * i + 1, lane(s.vs, w, pick));
        end
      4'd5, 4'd6, 4'd7, 4'd8:
        for (int i = 0; i < 4; i++) begin
          b = s.vs[8 * (i + ((s.m == 4'd6 || s.m == 4'd8) ? 4 : 0)) +: 8];
          if ((s.m == 4'd7 || s.m == 4'd8) && b[7])
            r = put(r, 16, i, {8'hFF, b});
          else
            r = put(r, 16, i, {8'h00, b});
        end
      4'd9:  r = {lane(s.vs,16,2), lane(s.vt,16,3), lane(s.vs,16,0), lane(s.vt,16,1)};
      4'd10: r = {lane(s.vs,16,0), lane(s.vt,16,1), lane(s.vs,16,2), lane(s.vt,16,3)};
      4'd11: r = {lane(s.vs,16,3), lane(s.vs,16,2), lane(s.vt,16,3), lane(s.vt,16,2)};
      4'd12: r = {lane(s.vs,16,1), lane(s.vs,16,0), lane(s.vt,16,1), lane(s.vt,16,0)};
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, r};
  endfunction

  function automatic string reqOf(input stim_t s);
    if (s.m == 4'd0) begin
      if (s.ur) return "R5";
      return s.be ? "R3" : "R4";
    end
    if (s.m > 4'd12) return "R11";
    if (s.be) return "R6";
    if (s.m <= 4'd2) return "R7";
    if (s.m <= 4'd4) return "R8";
    if (s.m <= 4'd8) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input stim_t s);
    mode = s.m; halfFmt = s.hf; bigEndian = s.be; useRegOffset = s.ur;
    immOffset = s.imm; regOffset = s.rg; vecS = s.vs; vecT = s.vt;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [64:0] lastExp;
    logic [64:0] e1, e2;
    stim_t s;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {modeErr, outVec}, 65'd0);
    check("R1", {64'd0, outValid}, 65'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    lastExp = '0;
    for (int k = 0; k < NV; k++) begin
      apply(TBL[k]);
      inValid = 1'b1;
      @(negedge clk);
      lastExp = refModel(TBL[k]);
      check(reqOf(TBL[k]), {modeErr, outVec}, lastExp);
      check("R2", {64'd0, outValid}, 65'd1);
    end

    // R2 idle: output holds while inputs change
    inValid = 1'b0;
    vecS = ~vecS; mode = 4'd0;
    @(negedge clk);
    check("R2", {64'd0, outValid}, 65'd0);
    check("R2", {modeErr, outVec}, lastExp);
    repeat (2) @(negedge clk);
    check("R2", {modeErr, outVec}, lastExp);

    // R6 endian input ignored by a pack operation, seen at output
    s = '{4'd2, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB};
    apply(s); inValid = 1'b1;
    @(negedge clk);
    e1 = {modeErr, outVec};
    s.be = 1'b1; apply(s);
    @(negedge clk);
    e2 = {modeErr, outVec};
    check("R6", e2, e1);

    // R5 upper register bits ignored: same low bits, different high bits
    s = '{4'd0, 1'b0, 1'b1, 1'b1, 3'd0, 64'd5, SA, TB};
    apply(s);
    @(negedge clk);
    e1 = {modeErr, outVec};
    s.rg = 64'hA5A5_0000_0000_00F5; apply(s);
    @(negedge clk);
    check("R5", {modeErr, outVec}, e1);
    check("R5", {modeErr, outVec}, refModel(s));

    // R11 then a valid code clears the flag
    s = '{4'd13, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB};
    apply(s);
    @(negedge clk);
    check("R11", {modeErr, outVec}, {1'b1, 64'd0});
    s = '{4'd12, 1'b0, 1'b0, 1'b0, 3'd0, 64'd0, SA, TB};
    apply(s);
    @(negedge clk);
    check("R11", {modeErr, outVec}, refModel(s));

    // R1 reset mid-run clears outputs
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R1", {modeErr, outVec}, 65'd0);
    check("R1", {64'd0, outValid}, 65'd0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule